// File: doc/BRIEF.md
# Cascade Output Shift Controller

This block turns a 24-bit output image into a serial stream for a chain of external 8-bit shift registers. The image is split into three byte groups. Each time the image is refreshed, the block shifts the enabled groups out on a data pin and a divided shift clock, and then pulses a store strobe. The strobe moves the shifted bits to the parallel outputs of the external devices. Software writes the image and a configuration word through a small word-wide register port.

Some bits of the image can be handed to hardware. A two-bit status source from a DSL modem and four three-bit status sources from Ethernet PHYs can each take over their own field of the image, bit by bit, under separate enable bits. A change on an enabled hardware source starts a new transfer on its own. A refresh that is asked for while a transfer is running is held and sent once that transfer has ended. The configuration also selects which byte groups are in the chain and on which clock edge the external registers sample.

Top module: `shift_out_top`

## Requirements
- R1: After reset the image register holds the RESET_IMAGE parameter and the configuration reads 0x000007 (all three groups on, falling-edge sampling, no overrides). Busy and store are 0, the shift clock idles high, and no transfer starts until a trigger arrives.
- R2: Register address 0 is the image, bits 23:0, read and write. Address 1 is the configuration, read and write. Its fields are: bits 2:0 the group mask (bit g enables image byte g), bit 3 rising-edge select, bits 5:4 the DSL override enable, and bits 6+3n+2:6+3n the override enable of PHY n (n = 0..3). Address 2 bit 0 is the busy status. Address 3 returns the merged image. Reads are combinational.
- R3: Merged bit k equals the hardware value when its override enable is set, and the image register bit otherwise. DSL input bit i maps to image bit i (i = 0..1). PHY n input bit j (phyIn[3n+j]) maps to image bit 2+3n+j.
- R4: A transfer shifts 8 times the number of enabled groups bits. It starts with the highest enabled group, skips disabled groups, and sends each byte most significant bit first.
- R5: With a group mask of 0, triggers cause no transfer, no busy and no store pulse. Re-enabling groups afterwards does not start a transfer by itself.
- R6: A write to address 0 starts a transfer, even when it writes the value already held. A change of the enabled part of the hardware inputs (input AND enable) starts a transfer. A change on an input whose enable is clear does not. A write to address 1 starts one only when it changes that enabled part.
- R7: Any number of triggers during a busy period produce exactly one further transfer after the current one, carrying the values current at its start.
- R8: Each bit lasts CLK_DIV system clocks. With bit 3 clear, the clock is high for the first half of the bit and low for the second, so data is sampled on the falling edge and the clock idles high. With bit 3 set, the levels are inverted: sampling is on the rising edge and the clock idles low. Data changes only at bit boundaries.
- R9: After the last bit, the store strobe is high for exactly CLK_DIV system clocks, with the shift clock at its idle level.
- R10: Busy is 1 from the first cycle of the shift until the last cycle of the store strobe. It is visible on the busy port and at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 24 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 24 | Register read data |
| dslIn | input | 2 | DSL modem status bits |
| phyIn | input | 12 | PHY status bits, three per PHY |
| shClk | output | 1 | Shift clock to the cascade |
| shData | output | 1 | Serial data to the cascade |
| shStore | output | 1 | Store strobe to the cascade |
| busy | output | 1 | Transfer in progress |

## Verification
The bench targets the group packing: masks with holes and single groups must come out as compact frames. A packer that left gaps or shifted from the wrong end would send the wrong bytes or the wrong length. It fires several image writes while a long frame is still shifting. A design that dropped the held request would send one frame too few, and one that queued every request would send too many. It changes hardware inputs whose enable is clear and checks that nothing is sent. It also writes an image with the group mask at zero. A trigger that ignored the enables would produce a frame, and a design that kept the zero-mask request would fire a stray frame when groups are switched back on. Bit spacing, sampling polarity in both edge modes and the store-pulse width are measured at the pins, so an off-by-one divider or a short store pulse shows up directly.

// File: rtl/so_pkg.sv
package so_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_STORE = 2'd2
  } ctlState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;   // capture packed image into the shifter
    logic shift;  // advance shifter by one bit
  } dpStrobe_t;

endpackage

// File: rtl/so_datapath.sv
module so_datapath
  import so_pkg::*;
#(
  parameter int GROUPS      = 3,
  parameter int GROUP_W     = 8,
  parameter int DSL_W       = 2,
  parameter int NUM_PHY     = 4,
  parameter int PHY_W       = 3,
  parameter logic [GROUPS*GROUP_W-1:0] RESET_IMAGE = '0,
  localparam int IMG_W      = GROUPS * GROUP_W,
  localparam int OVR_W      = DSL_W + NUM_PHY * PHY_W,
  localparam int CFG_W      = GROUPS + 1 + OVR_W,
  localparam int CNT_W      = $clog2(IMG_W + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [1:0]               wrAddr,
  input  logic [IMG_W-1:0]         wrData,
  input  logic [1:0]               rdAddr,
  output logic [IMG_W-1:0]         rdData,
  input  logic [DSL_W-1:0]         dslIn,
  input  logic [NUM_PHY*PHY_W-1:0] phyIn,
  input  dpStrobe_t                strb,
  input  logic                     busy,
  output logic                     trigger,
  output logic [CNT_W-1:0]         bitTotal,
  output logic                     cfgRising,
  output logic                     shData
);

  logic [IMG_W-1:0]  swImage;
  logic [GROUPS-1:0] cfgGroups;
  logic [OVR_W-1:0]  cfgOvrEn;
  logic [OVR_W-1:0]  ovrIn;
  logic [OVR_W-1:0]  ovrMasked;
  logic [OVR_W-1:0]  ovrPrev;
  logic [IMG_W-1:0]  merged;
  logic [IMG_W-1:0]  packImg;
  logic [IMG_W-1:0]  shReg;
  logic              imgWrite;
  logic              cfgWrite;

  assign imgWrite = wrEn && (wrAddr == 2'd0);
  assign cfgWrite = wrEn && (wrAddr == 2'd1);

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swImage   <= RESET_IMAGE;
      cfgGroups <= '1;
      cfgRising <= 1'b0;
      cfgOvrEn  <= '0;
    end else begin
      if (imgWrite) swImage <= wrData;
      if (cfgWrite) {cfgOvrEn, cfgRising, cfgGroups} <= wrData[CFG_W-1:0];
    end
  end

  // hardware sources side by side: DSL in the low bits, PHYs above
  assign ovrIn     = {phyIn, dslIn};
  assign ovrMasked = ovrIn & cfgOvrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovrPrev <= '0;
    else       ovrPrev <= ovrMasked;
  end

  assign trigger = imgWrite || (ovrMasked != ovrPrev);

  // per-bit merge; bits above the override span stay software-owned
  for (genvar b = 0; b < IMG_W; b++) begin : g_merge
    if (b < OVR_W) begin : g_ovr
      assign merged[b] = cfgOvrEn[b] ? ovrIn[b] : swImage[b];
    end else begin : g_sw
      assign merged[b] = swImage[b];
    end
  end

  // compact enabled groups, highest group at the top
  always_comb begin
    int slot;
    slot    = 0;
    packImg = '0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      if (cfgGroups[g]) begin
        packImg[IMG_W-1-slot*GROUP_W -: GROUP_W] = merged[g*GROUP_W +: GROUP_W];
        slot++;
      end
    end
    bitTotal = CNT_W'(slot * GROUP_W);
  end

  // output shifter, MSB leaves first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shReg <= '0;
    else if (strb.load)  shReg <= packImg;
    else if (strb.shift) shReg <= shReg << 1;
  end

  assign shData = shReg[IMG_W-1];

  // read mux
  always_comb begin
    case (rdAddr)
      2'd0:    rdData = swImage;
      2'd1:    rdData = IMG_W'({cfgOvrEn, cfgRising, cfgGroups});
      2'd2:    rdData = IMG_W'(busy);
      default: rdData = merged;
    endcase
  end

endmodule

// File: rtl/so_control.sv
module so_control
  import so_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 5,
  localparam int DIV_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1,
  localparam int HALF   = CLK_DIV / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigger,
  input  logic [CNT_W-1:0] bitTotal,
  input  logic             cfgRising,
  output dpStrobe_t        strb,
  output logic             shClk,
  output logic             shStore,
  output logic             busy
);

  ctlState_e        state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitsLeft;
  logic             pending;
  logic             periodEnd;
  logic             clkActive;

  assign periodEnd = (divCnt == DIV_W'(CLK_DIV - 1));

  // request memory: one slot, refilled by any trigger
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pending <= 1'b0;
    else if (trigger)           pending <= 1'b1;
    else if (state == ST_IDLE)  pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      bitsLeft <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pending && bitTotal != '0) begin
            state    <= ST_SHIFT;
            divCnt   <= '0;
            bitsLeft <= bitTotal;
          end
        end
        ST_SHIFT: begin
          if (periodEnd) begin
            divCnt <= '0;
            if (bitsLeft == CNT_W'(1)) state <= ST_STORE;
            else                       bitsLeft <= bitsLeft - CNT_W'(1);
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_STORE: begin
          if (periodEnd) begin
            divCnt <= '0;
            state  <= ST_IDLE;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load  = (state == ST_IDLE) && pending && (bitTotal != '0);
    strb.shift = (state == ST_SHIFT) && periodEnd;
  end

  assign clkActive = (state == ST_SHIFT) && (divCnt >= DIV_W'(HALF));
  assign shClk     = cfgRising ? clkActive : !clkActive;
  assign shStore   = (state == ST_STORE);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/shift_out_top.sv
module shift_out_top
  import so_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter logic [23:0] RESET_IMAGE = 24'h000000,
  localparam int GROUPS  = 3,
  localparam int GROUP_W = 8,
  localparam int DSL_W   = 2,
  localparam int NUM_PHY = 4,
  localparam int PHY_W   = 3,
  localparam int IMG_W   = GROUPS * GROUP_W,
  localparam int CNT_W   = $clog2(IMG_W + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [1:0]               wrAddr,
  input  logic [IMG_W-1:0]         wrData,
  input  logic [1:0]               rdAddr,
  output logic [IMG_W-1:0]         rdData,
  input  logic [DSL_W-1:0]         dslIn,
  input  logic [NUM_PHY*PHY_W-1:0] phyIn,
  output logic                     shClk,
  output logic                     shData,
  output logic                     shStore,
  output logic                     busy
);

  dpStrobe_t        strb;
  logic             trigger;
  logic [CNT_W-1:0] bitTotal;
  logic             cfgRising;

  so_datapath #(
    .GROUPS(GROUPS), .GROUP_W(GROUP_W), .DSL_W(DSL_W),
    .NUM_PHY(NUM_PHY), .PHY_W(PHY_W), .RESET_IMAGE(RESET_IMAGE)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .dslIn(dslIn), .phyIn(phyIn),
    .strb(strb), .busy(busy),
    .trigger(trigger), .bitTotal(bitTotal),
    .cfgRising(cfgRising), .shData(shData)
  );

  so_control #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .trigger(trigger), .bitTotal(bitTotal), .cfgRising(cfgRising),
    .strb(strb), .shClk(shClk), .shStore(shStore), .busy(busy)
  );

endmodule

// File: rtl/so_checker.sv
module so_checker #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic shClk,
  input logic shData,
  input logic shStore,
  input logic busy,
  input logic cfgRising
);

  logic [15:0] storeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        storeCnt <= '0;
    else if (shStore) storeCnt <= storeCnt + 16'd1;
    else              storeCnt <= '0;
  end

  // store pulse lies inside the busy window
  p_store_in_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    shStore |-> busy);

  // busy ends only right after the store pulse
  p_busy_ends_after_store_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(shStore));

  // store pulse width is one shift period
  p_store_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shStore) |-> (storeCnt == 16'(CLK_DIV)));

  // data held across the sampling edge, rising mode
  p_data_stable_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRising && $rose(shClk)) |-> $stable(shData));

  // data held across the sampling edge, falling mode
  p_data_stable_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgRising && $fell(shClk)) |-> $stable(shData));

  // clock parked at idle level while strobing
  p_store_clock_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    shStore |-> (shClk == !cfgRising));

endmodule

bind shift_out_top so_checker #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rstN(rstN), .shClk(shClk), .shData(shData),
  .shStore(shStore), .busy(busy), .cfgRising(cfgRising)
);

// File: tb/sim_shift_out_top.sv
module sim_shift_out_top;

  localparam int CLK_PERIOD = 10;
  localparam int TB_DIV = 4;
  localparam logic [23:0] TB_RESET_IMG = 24'h5AC30F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [23:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [23:0] rdData;
  logic [1:0]  dslIn = '0;
  logic [11:0] phyIn = '0;
  logic        shClk, shData, shStore, busy;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_out_top #(.CLK_DIV(TB_DIV), .RESET_IMAGE(TB_RESET_IMG)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .dslIn(dslIn), .phyIn(phyIn),
    .shClk(shClk), .shData(shData), .shStore(shStore), .busy(busy)
  );

  // pin monitor
  logic        benchRising = 1'b0;
  logic        prevClk = 1'b1;
  logic        prevStore = 1'b0;
  logic        sampleEdge;
  logic [23:0] acc = '0;
  int          accLen = 0;
  int          sinceEdge = 0;
  int          spacingErr = 0;
  logic [23:0] lastFrame = '0;
  logic [23:0] prevFrame = '0;
  int          lastLen = 0;
  int          frameCount = 0;
  int          storeRun = 0;
  int          lastStoreLen = 0;
  int          busyCycles = 0;

  always @(negedge clk) begin
    if (rstN) begin
      sampleEdge = benchRising ? (shClk && !prevClk) : (!shClk && prevClk);
      if (sampleEdge && busy && !shStore) begin
        acc = {acc[22:0], shData};
        if (accLen > 0 && sinceEdge != TB_DIV) spacingErr++;
        accLen++;
        sinceEdge = 1;
      end else begin
        sinceEdge++;
      end
      if (shStore && !prevStore) begin
        prevFrame = lastFrame;
        lastFrame = acc;
        lastLen = accLen;
        frameCount++;
        acc = '0;
        accLen = 0;
      end
      if (shStore) storeRun++;
      else if (prevStore) begin
        lastStoreLen = storeRun;
        storeRun = 0;
      end
      if (busy) busyCycles++;
      prevClk = shClk;
      prevStore = shStore;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [23:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [23:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic wait_done();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  task automatic write_cfg(input logic [23:0] c);
    reg_write(2'd1, c);
    benchRising = c[3];
    wait_done();
  endtask

  task automatic set_hw(input logic [1:0] d, input logic [11:0] p);
    @(posedge clk); #1;
    dslIn = d; phyIn = p;
  endtask

  function automatic logic [23:0] pack(input logic [23:0] img, input logic [2:0] m);
    logic [23:0] r = '0;
    for (int g = 2; g >= 0; g--)
      if (m[g]) r = (r << 8) | 24'(img[g*8 +: 8]);
    return r;
  endfunction

  function automatic logic [23:0] exp_merge(input logic [23:0] sw, input logic [1:0] dEn,
                                            input logic [11:0] pEn, input logic [1:0] d,
                                            input logic [11:0] p);
    logic [23:0] en = {10'b0, pEn, dEn};
    logic [23:0] v  = {10'b0, p, d};
    return (sw & ~en) | (v & en);
  endfunction

  task automatic t_reset();
    logic [23:0] d;
    check("R1 shClk idle", 32'(shClk), 32'd1);
    check("R1 shStore", 32'(shStore), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    reg_read(2'd0, d); check("R1 image reset", 32'(d), 32'(TB_RESET_IMG));
    reg_read(2'd1, d); check("R1 config reset", 32'(d), 32'h7);
    repeat (20) @(negedge clk);
    check("R1 no frame after reset", 32'(frameCount), 32'd0);
  endtask

  task automatic t_full();
    int fc;
    logic [23:0] d;
    fc = frameCount;
    reg_write(2'd0, 24'h123456);
    reg_read(2'd0, d); check("R2 image readback", 32'(d), 32'h123456);
    wait_done();
    check("R6 write triggers", 32'(frameCount), 32'(fc + 1));
    check("R4 frame data", 32'(lastFrame), 32'h123456);
    check("R4 frame length", 32'(lastLen), 32'd24);
    check("R9 store width", 32'(lastStoreLen), 32'(TB_DIV));
    check("R8 bit spacing", 32'(spacingErr), 32'd0);
    reg_write(2'd0, 24'h123456);
    wait_done();
    check("R6 same-value write triggers", 32'(frameCount), 32'(fc + 2));
  endtask

  task automatic t_groups();
    int fc;
    fc = frameCount;
    write_cfg(24'h000005);
    check("R6 config write alone no frame", 32'(frameCount), 32'(fc));
    reg_write(2'd0, 24'hABCDEF);
    wait_done();
    check("R4 mask 101 data", 32'(lastFrame[15:0]), 32'(pack(24'hABCDEF, 3'b101)));
    check("R4 mask 101 length", 32'(lastLen), 32'd16);
    write_cfg(24'h000002);
    reg_write(2'd0, 24'h13579B);
    wait_done();
    check("R4 mask 010 data", 32'(lastFrame[7:0]), 32'h57);
    check("R4 mask 010 length", 32'(lastLen), 32'd8);
  endtask

  task automatic t_zero_mask();
    int fc, bc;
    write_cfg(24'h000000);
    fc = frameCount; bc = busyCycles;
    reg_write(2'd0, 24'hFFEE11);
    wait_done();
    check("R5 no frame with mask 0", 32'(frameCount), 32'(fc));
    check("R5 no busy with mask 0", 32'(busyCycles), 32'(bc));
    write_cfg(24'h000007);
    check("R5 re-enable starts nothing", 32'(frameCount), 32'(fc));
  endtask

  task automatic t_busy();
    logic [23:0] d;
    reg_write(2'd0, 24'h0F0F0F);
    repeat (3) @(negedge clk);
    check("R10 busy port during shift", 32'(busy), 32'd1);
    reg_read(2'd2, d); check("R10 busy register", 32'(d), 32'd1);
    wait_done();
    reg_read(2'd2, d); check("R10 busy clear after store", 32'(d), 32'd0);
  endtask

  task automatic t_rising();
    write_cfg(24'h00000F);
    check("R8 rising idle low", 32'(shClk), 32'd0);
    reg_write(2'd0, 24'hA1B2C3);
    wait_done();
    check("R8 rising frame data", 32'(lastFrame), 32'hA1B2C3);
    check("R8 rising spacing", 32'(spacingErr), 32'd0);
    write_cfg(24'h000007);
    check("R8 falling idle high", 32'(shClk), 32'd1);
  endtask

  task automatic t_override();
    int fc;
    logic [23:0] d, e;
    fc = frameCount;
    set_hw(2'b10, 12'hABC);
    wait_done();
    check("R6 disabled input change ignored", 32'(frameCount), 32'(fc));
    // dsl 11, phy0 101, phy3 111
    write_cfg(24'h038177);
    reg_read(2'd1, d); check("R2 config readback", 32'(d), 32'h038177);
    reg_write(2'd0, 24'h000000);
    wait_done();
    e = exp_merge(24'h000000, 2'b11, 12'b111_000_000_101, 2'b10, 12'hABC);
    check("R3 merged frame from zero", 32'(lastFrame), 32'(e));
    reg_read(2'd3, d); check("R3 merged readback", 32'(d), 32'(e));
    reg_write(2'd0, 24'hFFFFFF);
    wait_done();
    e = exp_merge(24'hFFFFFF, 2'b11, 12'b111_000_000_101, 2'b10, 12'hABC);
    check("R3 merged frame from ones", 32'(lastFrame), 32'(e));
    fc = frameCount;
    set_hw(2'b01, 12'hABC);
    wait_done();
    check("R6 enabled input change triggers", 32'(frameCount), 32'(fc + 1));
    e = exp_merge(24'hFFFFFF, 2'b11, 12'b111_000_000_101, 2'b01, 12'hABC);
    check("R3 frame follows input", 32'(lastFrame), 32'(e));
    fc = frameCount;
    set_hw(2'b01, 12'hABC ^ 12'h038);
    wait_done();
    check("R6 disabled phy1 change ignored", 32'(frameCount), 32'(fc));
    reg_read(2'd3, d); check("R6 merged unchanged", 32'(d), 32'(e));
    write_cfg(24'h000007);
  endtask

  task automatic t_resend();
    int fc;
    fc = frameCount;
    reg_write(2'd0, 24'h111111);
    while (!busy) @(negedge clk);
    reg_write(2'd0, 24'h222222);
    reg_write(2'd0, 24'h333333);
    wait_done();
    check("R7 one extra frame", 32'(frameCount), 32'(fc + 2));
    check("R7 first frame", 32'(prevFrame), 32'h111111);
    check("R7 resent latest", 32'(lastFrame), 32'h333333);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_full();
    t_groups();
    t_zero_mask();
    t_busy();
    t_rising();
    t_override();
    t_resend();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule